// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This unit holds the program counter of a small 8-bit controller whose program space is 10, 11 or 12 bits wide, and picks its next value once per instruction cycle. The next address comes from one of several sources. It can be a plain increment or a taken conditional skip. It can be a jump or call target taken from the instruction, or a return address from the stack. It can be a write to the low byte of the counter, or a fixed interrupt vector. Reset is the remaining source. The unit advances only when the cycle-enable strobe `cyc_en` is high. Between strobes it holds its state.

Any change of program flow puts the unit in a one-cycle bubble. A taken skip, a low-byte write, a jump, a return or an interrupt entry raises `flush`. `flush` stays high for the whole next instruction cycle, so the pipeline throws away the word it prefetched. A two-state machine tracks this. The states are `ST_RUN`, which is normal fetching, and `ST_FLUSH`, which is the dummy cycle.

The machine moves as follows:
- `ST_RUN` goes to `ST_FLUSH` on a strobe with a redirecting source.
- `ST_RUN` stays in `ST_RUN` on a strobe that only increments.
- `ST_FLUSH` goes back to `ST_RUN` on a strobe with no interrupt pending.
- `ST_FLUSH` stays in `ST_FLUSH` when an interrupt vector is taken during the bubble.

Reset from either state leads to `ST_RUN`.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter becomes 0x000 and `flush` becomes 0, whatever the other inputs are.
- R2: At an edge where `cyc_en` is low, the counter and `flush` keep their values and all requests are ignored.
- R3: A strobe with no request taken adds 1 to the counter. The top address wraps to 0x000. `flush` is 0 afterwards.
- R4: An interrupt request loads a vector. The external request (`irq_ext`) loads 0x004, the timer request (`irq_tmr`) loads 0x008 and the converter request (`irq_adc`) loads 0x00C. If several are high, external wins over timer, and timer wins over converter. `flush` is 1 afterwards.
- R5: A return (`ret_req`) loads every counter bit from `ret_addr`, and `flush` is 1 afterwards.
- R6: A jump or call (`jmp_req`) loads every counter bit from `jmp_addr`, and `flush` is 1 afterwards.
- R7: A low-byte write (`pcl_wr`) puts `pcl_wdata` into counter bits 7..0 and keeps the upper bits, so the target stays in the current 256-word page. `flush` is 1 afterwards.
- R8: A taken skip (`skip_req`) adds 2 to the counter, wrapping past the top address, and `flush` is 1 afterwards.
- R9: When several sources are requested together, the order is reset, then interrupt, then return, then jump, then low-byte write, then skip, then increment.
- R10: During a bubble cycle (`flush` = 1), return, jump, low-byte write and skip requests are ignored and the counter increments. An interrupt request is still taken and keeps `flush` at 1.
- R11: `pcl_rd` always equals counter bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle strobe |
| irq_ext | input | 1 | External interrupt acknowledge |
| irq_tmr | input | 1 | Timer overflow interrupt acknowledge |
| irq_adc | input | 1 | Converter-complete interrupt acknowledge |
| ret_req | input | 1 | Return from subroutine or interrupt |
| ret_addr | input | PC_W | Top-of-stack address |
| jmp_req | input | 1 | Jump or call |
| jmp_addr | input | PC_W | Target address field of the instruction |
| pcl_wr | input | 1 | Write to the low-byte register |
| pcl_wdata | input | 8 | Low byte being written |
| skip_req | input | 1 | Conditional skip whose condition is true |
| fetch_addr | output | PC_W | Counter value, used as the fetch address |
| pcl_rd | output | 8 | Readable low byte of the counter |
| flush | output | 1 | Dummy-cycle flag: discard the prefetched word |

## Verification
Each result is due one edge after the strobe that causes it, because only the counter and state registers sit between the inputs and the outputs. The bench therefore drives every request on the falling edge and holds it across exactly one rising edge. It then samples `fetch_addr`, `pcl_rd` and `flush` shortly after that rising edge. A bubble's effect on the next strobe is checked in the vector after the redirect, because that is the first edge at which a masked request could show. Hold behaviour is checked by sampling after an edge with the strobe low.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    typedef enum logic [2:0] {
        SRC_INC  = 3'd0,
        SRC_SKIP = 3'd1,
        SRC_PCL  = 3'd2,
        SRC_JMP  = 3'd3,
        SRC_RET  = 3'd4,
        SRC_IRQ  = 3'd5
    } pc_src_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } flow_state_t;

    localparam logic [3:0] VEC_EXT = 4'h4;
    localparam logic [3:0] VEC_TMR = 4'h8;
    localparam logic [3:0] VEC_ADC = 4'hC;
    localparam int         PCL_W   = 8;

endpackage

// File: rtl/pcnu_arbiter.sv
module pcnu_arbiter
    import pcnu_pkg::*;
(
    input  logic       in_bubble,
    input  logic       irq_ext,
    input  logic       irq_tmr,
    input  logic       irq_adc,
    input  logic       ret_req,
    input  logic       jmp_req,
    input  logic       pcl_wr,
    input  logic       skip_req,
    output pc_src_t    src,
    output logic [3:0] vec_lo
);

    logic any_irq;
    logic instr_ok;

    assign any_irq  = irq_ext | irq_tmr | irq_adc;
    assign instr_ok = ~in_bubble;

    always_comb begin
        if (irq_ext)      vec_lo = VEC_EXT;
        else if (irq_tmr) vec_lo = VEC_TMR;
        else              vec_lo = VEC_ADC;
    end

    always_comb begin
        if (any_irq)                   src = SRC_IRQ;
        else if (instr_ok && ret_req)  src = SRC_RET;
        else if (instr_ok && jmp_req)  src = SRC_JMP;
        else if (instr_ok && pcl_wr)   src = SRC_PCL;
        else if (instr_ok && skip_req) src = SRC_SKIP;
        else                           src = SRC_INC;
    end

endmodule

// File: rtl/pcnu_addr_calc.sv
module pcnu_addr_calc
    import pcnu_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic [PC_W-1:0] pc,
    input  pc_src_t         src,
    input  logic [3:0]      vec_lo,
    input  logic [PC_W-1:0] ret_addr,
    input  logic [PC_W-1:0] jmp_addr,
    input  logic [7:0]      pcl_wdata,
    output logic [PC_W-1:0] pc_next
);

    localparam int PAGE_W = PC_W - PCL_W;

    logic [PC_W-1:0] page_load;
    logic [PC_W-1:0] vec_addr;

    generate
        if (PAGE_W > 0) begin : g_paged
            assign page_load = {pc[PC_W-1:PCL_W], pcl_wdata};
        end else begin : g_flat
            assign page_load = pcl_wdata[PC_W-1:0];
        end
    endgenerate

    assign vec_addr = {{(PC_W-4){1'b0}}, vec_lo};

    always_comb begin
        unique case (src)
            SRC_IRQ:  pc_next = vec_addr;
            SRC_RET:  pc_next = ret_addr;
            SRC_JMP:  pc_next = jmp_addr;
            SRC_PCL:  pc_next = page_load;
            SRC_SKIP: pc_next = pc + PC_W'(2);
            default:  pc_next = pc + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/pcnu_flow_fsm.sv
module pcnu_flow_fsm
    import pcnu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cyc_en,
    input  pc_src_t src,
    output logic    in_bubble,
    output logic    flush
);

    flow_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cyc_en) begin
            unique case (state_q)
                ST_RUN:   state_d = (src == SRC_INC) ? ST_RUN : ST_FLUSH;
                ST_FLUSH: state_d = (src == SRC_IRQ) ? ST_FLUSH : ST_RUN;
                default:  state_d = ST_RUN;
            endcase
        end
    end

    always_comb begin
        in_bubble = (state_q == ST_FLUSH);
        flush     = (state_q == ST_FLUSH);
    end

    AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && src != SRC_INC) |=> flush);  // R6

    AST_BUBBLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && flush && src != SRC_IRQ) |=> !flush);  // R10

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcnu_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_en,
    input  logic            irq_ext,
    input  logic            irq_tmr,
    input  logic            irq_adc,
    input  logic            ret_req,
    input  logic [PC_W-1:0] ret_addr,
    input  logic            jmp_req,
    input  logic [PC_W-1:0] jmp_addr,
    input  logic            pcl_wr,
    input  logic [7:0]      pcl_wdata,
    input  logic            skip_req,
    output logic [PC_W-1:0] fetch_addr,
    output logic [7:0]      pcl_rd,
    output logic            flush
);

    pc_src_t         src;
    logic [3:0]      vec_lo;
    logic            in_bubble;
    logic [PC_W-1:0] pc_q, pc_next;

    pcnu_arbiter u_arb (
        .in_bubble (in_bubble),
        .irq_ext   (irq_ext),
        .irq_tmr   (irq_tmr),
        .irq_adc   (irq_adc),
        .ret_req   (ret_req),
        .jmp_req   (jmp_req),
        .pcl_wr    (pcl_wr),
        .skip_req  (skip_req),
        .src       (src),
        .vec_lo    (vec_lo)
    );

    pcnu_addr_calc #(.PC_W(PC_W)) u_calc (
        .pc        (pc_q),
        .src       (src),
        .vec_lo    (vec_lo),
        .ret_addr  (ret_addr),
        .jmp_addr  (jmp_addr),
        .pcl_wdata (pcl_wdata),
        .pc_next   (pc_next)
    );

    pcnu_flow_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .src       (src),
        .in_bubble (in_bubble),
        .flush     (flush)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (cyc_en) pc_q <= pc_next;
    end

    assign fetch_addr = pc_q;
    assign pcl_rd     = pc_q[7:0];

    AST_RESET_ORIGIN: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == '0 && !flush));  // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> ($stable(fetch_addr) && $stable(flush)));  // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && src == SRC_INC) |=>
        (fetch_addr == PC_W'($past(fetch_addr) + 1) && !flush));  // R3

    AST_PCL_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && src == SRC_PCL) |=>
        (fetch_addr[PC_W-1:8] == $past(fetch_addr[PC_W-1:8])));  // R7

    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && ret_req && !flush && !(irq_ext || irq_tmr || irq_adc)) |=>
        (fetch_addr == $past(ret_addr)));  // R5

endmodule

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;

    localparam int W = 10;
    localparam int N = 27;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc_en = 1'b0;
    logic         irq_ext = 1'b0, irq_tmr = 1'b0, irq_adc = 1'b0;
    logic         ret_req = 1'b0, jmp_req = 1'b0, pcl_wr = 1'b0, skip_req = 1'b0;
    logic [W-1:0] ret_addr = '0, jmp_addr = '0;
    logic [7:0]   pcl_wdata = '0;
    logic [W-1:0] fetch_addr;
    logic [7:0]   pcl_rd;
    logic         flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pc_next_unit #(.PC_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
        .irq_ext(irq_ext), .irq_tmr(irq_tmr), .irq_adc(irq_adc),
        .ret_req(ret_req), .ret_addr(ret_addr),
        .jmp_req(jmp_req), .jmp_addr(jmp_addr),
        .pcl_wr(pcl_wr), .pcl_wdata(pcl_wdata), .skip_req(skip_req),
        .fetch_addr(fetch_addr), .pcl_rd(pcl_rd), .flush(flush)
    );

    // ctrl = {cyc, ext, tmr, adc, ret, jmp, pcl, skip}; data feeds all address inputs
    localparam logic [28:0] VEC [N] = '{
        {8'b1000_0000, 10'h000, 10'h001, 1'b0},  // R3
        {8'b1000_0000, 10'h000, 10'h002, 1'b0},  // R3
        {8'b1000_0100, 10'h1F0, 10'h1F0, 1'b1},  // R6
        {8'b1000_0000, 10'h000, 10'h1F1, 1'b0},  // R10
        {8'b1000_0001, 10'h000, 10'h1F3, 1'b1},  // R8
        {8'b1000_0100, 10'h055, 10'h1F4, 1'b0},  // R10 jump masked
        {8'b1000_0010, 10'h020, 10'h120, 1'b1},  // R7
        {8'b1000_0000, 10'h000, 10'h121, 1'b0},  // R3
        {8'b1000_1000, 10'h3FE, 10'h3FE, 1'b1},  // R5
        {8'b1000_0000, 10'h000, 10'h3FF, 1'b0},  // R3
        {8'b1000_0000, 10'h000, 10'h000, 1'b0},  // R3 wrap
        {8'b0000_0100, 10'h111, 10'h000, 1'b0},  // R2
        {8'b1010_1100, 10'h222, 10'h008, 1'b1},  // R4 R9
        {8'b1001_0000, 10'h000, 10'h00C, 1'b1},  // R10 irq in bubble
        {8'b1000_0000, 10'h000, 10'h00D, 1'b0},  // R3
        {8'b1111_0000, 10'h000, 10'h004, 1'b1},  // R4 priority
        {8'b1000_0000, 10'h000, 10'h005, 1'b0},  // R3
        {8'b1000_1111, 10'h3FF, 10'h3FF, 1'b1},  // R9 ret first
        {8'b1000_0000, 10'h000, 10'h000, 1'b0},  // R3 wrap
        {8'b1000_0111, 10'h0C8, 10'h0C8, 1'b1},  // R9 jmp over pcl
        {8'b1000_0000, 10'h000, 10'h0C9, 1'b0},  // R3
        {8'b1000_0011, 10'h3FF, 10'h0FF, 1'b1},  // R9 pcl over skip
        {8'b1000_0000, 10'h000, 10'h100, 1'b0},  // R3
        {8'b1000_0100, 10'h3FE, 10'h3FE, 1'b1},  // R6
        {8'b1000_0000, 10'h000, 10'h3FF, 1'b0},  // R3
        {8'b1000_0001, 10'h000, 10'h001, 1'b1},  // R8 wrap
        {8'b1000_0000, 10'h000, 10'h002, 1'b0}   // R3
    };

    task automatic drive(input logic [7:0] c, input logic [9:0] d);
        @(negedge clk);
        {cyc_en, irq_ext, irq_tmr, irq_adc, ret_req, jmp_req, pcl_wr, skip_req} = c;
        ret_addr  = d;
        jmp_addr  = d;
        pcl_wdata = d[7:0];
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [9:0] ea, input logic ef);
        checks++;
        if (fetch_addr !== ea || flush !== ef) begin
            errors++;
            $display("FAIL %s: addr %h flush %b, expected addr %h flush %b",
                     req, fetch_addr, flush, ea, ef);
        end
        checks++;
        if (pcl_rd !== ea[7:0]) begin
            errors++;
            $display("FAIL R11: pcl_rd %h, expected %h", pcl_rd, ea[7:0]);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(8'b1111_1111, 10'h3AA);
        drive(8'b1111_1111, 10'h3AA);
        check("R1", 10'h000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            drive(VEC[i][28:21], VEC[i][20:11]);
            check($sformatf("vec%0d R3-table", i), VEC[i][10:1], VEC[i][0]);
        end

        // R2: several idle edges with requests present, state held
        drive(8'b0000_0001, 10'h000);
        drive(8'b0111_1111, 10'h2AB);
        check("R2", 10'h002, 1'b0);

        // R1: reset in the middle of a bubble
        drive(8'b1000_0100, 10'h2AB);
        check("R6", 10'h2AB, 1'b1);
        rst_n = 1'b0;
        drive(8'b1000_0100, 10'h155);
        check("R1", 10'h000, 1'b0);
        rst_n = 1'b1;
        drive(8'b1000_0010, 10'h0EE);
        check("R7", 10'h0EE, 1'b1);

        drive(8'b0000_0000, 10'h000);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule